// File: doc/BRIEF.md
# Transparent Dual-Port Register File

This block is a small storage array of four words, four bits each. It has one write port and one read port, and the two work independently. In the same clock cycle, a client can write one word and read a different one. Both enables are active-low. A write is committed on the rising clock edge while the write enable is asserted.

While a write is open, the read port passes the incoming data straight through when its address matches the write address. The value written on the coming edge is therefore visible at the output in the same cycle. It keeps tracking the data inputs until the edge.

When the read port is disabled, the data output is forced to zero and a separate valid flag drops. This flag stands in for a high-impedance state. A wrapper at chip level can turn the pair into a real tri-state driver, so that several banks can share one output bus. An active-low bank-select input, present when the parameter `USE_BANK` is 1, mutes both ports. This lets several banks be addressed as one larger array.

Top module: `xrf_top`

## Requirements
- R1: An asynchronous active-low reset clears every word to zero. After reset, enabled reads of all four addresses return 0.
- R2: When `wrEnN` is 0 at a rising clock edge, the word at `wrAddr` takes `wrData`. All other words keep their values.
- R3: When `wrEnN` is 1, `wrAddr` and `wrData` have no effect, and every stored word keeps its value across clock edges.
- R4: When `rdEnN` is 0, `rdValid` is 1 and `rdData` equals the stored word at `rdAddr`, bit for bit and not inverted.
- R5: When `rdEnN` is 1, `rdValid` is 0 and `rdData` is all zeros.
- R6: Read selection does not depend on the write port. A read at an address other than the open write address returns that word's stored value in the same cycle.
- R7: When `wrEnN` is 0 and `rdAddr` equals `wrAddr`, `rdData` equals the present `wrData` without a clock edge. It follows changes of `wrData` within the cycle, and the word then holds the value present at the edge.
- R8: With `USE_BANK` = 1 and `bankSelN` = 1, no write takes effect, `rdValid` is 0 and `rdData` is 0, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSelN | input | 1 | Active-low bank select (used when USE_BANK = 1) |
| wrEnN | input | 1 | Active-low write enable |
| wrAddr | input | 2 | Write word address |
| wrData | input | 4 | Write data |
| rdEnN | input | 1 | Active-low read enable |
| rdAddr | input | 2 | Read word address |
| rdData | output | 4 | Read data; zero when disabled |
| rdValid | output | 1 | High when the output is driven (low models high impedance) |

## Verification
On every clock edge, the assertions check four things: a write lands at its address, storage stays frozen when no write is strobed, the output is zero and invalid whenever the read enable or bank select is inactive, and a matching read during an open write returns the write data. Several behaviours can only be shown by the bench's scenarios, run against its own reference array. These are the reset contents, reading one word while a different one is written, the pass-through following a data change in the middle of a cycle and then holding it after the edge, and a muted bank keeping its contents.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic wrStrobe;   // commit wrData at the next rising edge
    logic rdStrobe;   // drive the read port
    logic bypass;     // read address hits the open write address
  } xrf_ctrl_t;

endpackage

// File: rtl/xrf_ctrl.sv
module xrf_ctrl
  import xrf_pkg::*;
#(
  parameter int AW       = 2,
  parameter bit USE_BANK = 1'b1
) (
  input  logic          bankSelN,
  input  logic          wrEnN,
  input  logic [AW-1:0] wrAddr,
  input  logic          rdEnN,
  input  logic [AW-1:0] rdAddr,
  output xrf_ctrl_t     ctrl
);

  logic bankOn;

  generate
    if (USE_BANK) begin : g_bank
      assign bankOn = ~bankSelN;
    end else begin : g_nobank
      logic unusedSel;
      assign unusedSel = bankSelN;
      assign bankOn    = 1'b1;
    end
  endgenerate

  always_comb begin
    ctrl          = '0;
    ctrl.wrStrobe = bankOn & ~wrEnN;
    ctrl.rdStrobe = bankOn & ~rdEnN;
    ctrl.bypass   = bankOn & ~wrEnN & (rdAddr == wrAddr);
  end

endmodule

// File: rtl/xrf_datapath.sv
module xrf_datapath
  import xrf_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int DW    = 4,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  xrf_ctrl_t     ctrl,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);

  logic [DW-1:0]       words [WORDS];
  logic [WORDS*DW-1:0] flatWords;

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DW-1:0] wordQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          wordQ <= '0;
        else if (ctrl.wrStrobe && (wrAddr == AW'(i)))
          wordQ <= wrData;
      end
      assign words[i]                = wordQ;
      assign flatWords[i*DW +: DW]   = wordQ;
    end
  endgenerate

  always_comb begin
    rdValid = ctrl.rdStrobe;
    rdData  = '0;
    if (ctrl.rdStrobe)
      rdData = ctrl.bypass ? wrData : words[rdAddr];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrStrobe |=> words[$past(wrAddr)] == $past(wrData)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrStrobe |=> $stable(flatWords)); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdStrobe && ctrl.bypass) |-> rdData == wrData); // R7

endmodule

// File: rtl/xrf_top.sv
module xrf_top
  import xrf_pkg::*;
#(
  parameter int WORDS    = 4,
  parameter int DW       = 4,
  parameter bit USE_BANK = 1'b1,
  localparam int AW      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bankSelN,
  input  logic          wrEnN,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEnN,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);

  xrf_ctrl_t ctrl;

  xrf_ctrl #(.AW(AW), .USE_BANK(USE_BANK)) u_ctrl (
    .bankSelN (bankSelN),
    .wrEnN    (wrEnN),
    .wrAddr   (wrAddr),
    .rdEnN    (rdEnN),
    .rdAddr   (rdAddr),
    .ctrl     (ctrl)
  );

  xrf_datapath #(.WORDS(WORDS), .DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdEnN |-> (!rdValid && rdData == '0)); // R5

  AST_BANK_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    (USE_BANK && bankSelN) |-> (!rdValid && rdData == '0)); // R8

endmodule

// File: tb/xrf_top_bench.sv
module xrf_top_bench;

  localparam int WORDS = 4;
  localparam int DW    = 4;
  localparam int AW    = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          bankSelN;
  logic          wrEnN;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          rdEnN;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic          rdValid;

  logic [DW-1:0] refMem [WORDS];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  xrf_top #(.WORDS(WORDS), .DW(DW), .USE_BANK(1'b1)) u_xrf_top (
    .clk(clk), .rstN(rstN), .bankSelN(bankSelN), .wrEnN(wrEnN),
    .wrAddr(wrAddr), .wrData(wrData), .rdEnN(rdEnN), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEnN = 1'b1; rdEnN = 1'b1; bankSelN = 1'b0;
  endtask

  // read one address with write idle; checks data and valid
  task automatic readWord(input string req, input int a);
    @(negedge clk);
    idle();
    rdEnN = 1'b0; rdAddr = AW'(a);
    #2;
    check(req, rdValid, 1);
    check(req, rdData, refMem[a]);
  endtask

  task automatic writeWord(input int a, input int d);
    @(negedge clk);
    idle();
    wrEnN = 1'b0; wrAddr = AW'(a); wrData = DW'(d);
    #2;
    check("R5", rdValid, 0);
    check("R5", rdData, 0);
    @(posedge clk);
    refMem[a] = DW'(d);
  endtask

  task automatic testReset();
    rstN = 1'b0; idle(); wrAddr = '0; wrData = '0; rdAddr = '0;
    for (int i = 0; i < WORDS; i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < WORDS; i++) readWord("R1", i);
  endtask

  task automatic testWriteRead();
    writeWord(0, 5); writeWord(1, 10); writeWord(2, 3); writeWord(3, 12);
    for (int i = 0; i < WORDS; i++) readWord("R2", i);
    readWord("R4", 1);
  endtask

  task automatic testIgnored();
    @(negedge clk);
    idle(); wrAddr = 2'd1; wrData = 4'hF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wrAddr = 2'd2; wrData = 4'h0;
    @(posedge clk);
    for (int i = 0; i < WORDS; i++) readWord("R3", i);
  endtask

  task automatic testConcurrent();
    @(negedge clk);
    idle();
    wrEnN = 1'b0; wrAddr = 2'd2; wrData = 4'h9;
    rdEnN = 1'b0; rdAddr = 2'd0;
    #2;
    check("R6", rdValid, 1);
    check("R6", rdData, refMem[0]);
    @(posedge clk);
    refMem[2] = 4'h9;
    readWord("R6", 2);
    readWord("R6", 0);
  endtask

  task automatic testPassThrough();
    @(negedge clk);
    idle();
    wrEnN = 1'b0; wrAddr = 2'd3; wrData = 4'h6;
    rdEnN = 1'b0; rdAddr = 2'd3;
    #2;
    check("R7", rdData, 6);
    wrData = 4'hE;
    #2;
    check("R7", rdData, 14);
    @(posedge clk);
    refMem[3] = 4'hE;
    readWord("R7", 3);
    readWord("R7", 1);
  endtask

  task automatic testReadOff();
    @(negedge clk);
    idle(); rdAddr = 2'd1;
    #2;
    check("R5", rdValid, 0);
    check("R5", rdData, 0);
  endtask

  task automatic testBank();
    @(negedge clk);
    idle();
    bankSelN = 1'b1; rdEnN = 1'b0; rdAddr = 2'd0;
    wrEnN = 1'b0; wrAddr = 2'd0; wrData = 4'h1;
    #2;
    check("R8", rdValid, 0);
    check("R8", rdData, 0);
    @(posedge clk);
    readWord("R8", 0);
  endtask

  initial begin
    testReset();
    testWriteRead();
    testIgnored();
    testConcurrent();
    testPassThrough();
    testReadOff();
    testBank();
    @(negedge clk);
    idle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule